// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block times the read side of a synchronous burst memory. A 16-bit configuration word sets the access timing. One field selects synchronous operation. Other fields set the first-access latency, the polarity of the WAIT output, whether WAIT releases one cycle early, the burst length and the address wrap behaviour. A start address arrives with a one-cycle address-valid strobe. The block waits out the latency and then presents one word per clock on a registered data output, with a data-valid flag beside it. The words come from an external lookup port: the block drives the word address, and the array returns the data combinationally in the same cycle.

Fixed bursts of 4, 8 or 16 words end on their own. A continuous burst runs until a terminate input is raised. A new strobe restarts the sequencer at any time. A non-array flag given with the strobe makes the burst repeat its first word for its whole length. The sequencer latches the timing fields at the strobe. The WAIT polarity field stays live, so a configuration write during a burst changes only the polarity.

The clock-edge field is stored and read back like the other writable fields. All outputs are launched on the rising edge.

Top module: `burst_read_seq`

## Requirements
- R1: After reset the configuration reads back 0xF94F. This is asynchronous mode, latency 15, WAIT active low, WAIT released early, rising edge, no wrap and continuous burst. After reset `dvalid` is 0 and `wait_o` is 1, the inactive level.
- R2: Configuration bits 9, 5 and 4 always read back as 0, whatever is written to them. All other bits read back as written.
- R3: Bit 15 = 0 selects synchronous mode, and bits 14:11 hold a latency code LC. Take the clock edge that samples `adv` as edge 0. The first word is valid after edge LC, and `dvalid` is 0 before that edge.
- R4: Latency codes 0 and 1 behave as code 15.
- R5: Bits 2:0 set the burst length. Code 001 gives 4 words, 010 gives 8 words and 011 gives 16 words. A fixed burst gives exactly that many consecutive valid cycles, and then `dvalid` returns to 0.
- R6: With bit 3 = 0 and a fixed length L, word k comes from address (A & ~(L-1)) | ((A + k) mod L), where A is the start address.
- R7: With bit 3 = 1, or in a continuous burst, word k comes from address A + k modulo 2^AW.
- R8: Code 111 and the reserved codes 000, 100, 101 and 110 give a continuous burst. A continuous burst stays valid until `term` is sampled high, and `dvalid` is 0 after that edge.
- R9: Bit 10 sets the WAIT polarity. With bit 10 = 0, `wait_o` is 0 while asserted and 1 otherwise. With bit 10 = 1, `wait_o` is 1 while asserted and 0 otherwise.
- R10: WAIT is asserted after edges 0 to LC-1. Bit 8 sets when it is released. With bit 8 = 0, WAIT is released after edge LC, together with the first word. With bit 8 = 1, WAIT is released after edge LC-1, one cycle before the first word. WAIT is never asserted while `dvalid` is 1.
- R11: In asynchronous mode (bit 15 = 1), `adv` is ignored and `dvalid` stays 0.
- R12: With `nonarray` high at the strobe, every word of the burst repeats the data at the start address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 16 | Configuration value to write |
| cfg_q | output | 16 | Stored configuration, with bits 9, 5 and 4 reading 0 |
| adv | input | 1 | Address-valid strobe; starts a burst in synchronous mode |
| start_addr | input | AW | Start word address, sampled with `adv` |
| nonarray | input | 1 | Sampled with `adv`: repeat the first word for the whole burst |
| term | input | 1 | Ends the current burst at the next edge |
| arr_addr | output | AW | Word address to the array lookup |
| arr_data | input | DW | Array data for `arr_addr`, valid in the same cycle |
| dout | output | DW | Registered burst data |
| dvalid | output | 1 | `dout` holds a valid burst word |
| wait_o | output | 1 | WAIT, with polarity set by configuration bit 10 |

## Verification
The assertions assume that `arr_data` settles within the cycle for the address on `arr_addr`. They also assume that `adv` and `term` are single-cycle pulses that are never raised together. The bench drives all inputs half a cycle away from the active edge. It gives the strobe for one cycle only, and it raises `term` only during a continuous burst. It writes the configuration only while the sequencer is idle, so the latched timing fields and the live polarity field always agree with the values the bench expects.

// File: rtl/brs_pkg.sv
package brs_pkg;

  localparam int CFG_W   = 16;
  localparam int LAT_W   = 4;
  localparam int LEN_LGW = 3;
  localparam int WCNT_W  = 5;

  localparam logic [CFG_W-1:0] CFG_RESET = 16'hF94F;
  localparam logic [CFG_W-1:0] CFG_FIXED0 = 16'h0230;

  typedef enum logic [1:0] {ST_IDLE, ST_LAT, ST_DATA} brs_state_e;

  typedef struct packed {
    logic               async_mode;
    logic [LAT_W-1:0]   lat;
    logic               wait_hi;
    logic               wait_early;
    logic               no_wrap;
    logic [LEN_LGW-1:0] len_lg;
  } brs_cfg_t;

  function automatic logic [LAT_W-1:0] eff_latency(input logic [LAT_W-1:0] code);
    return (code < 4'd2) ? 4'd15 : code;
  endfunction

  function automatic logic [LEN_LGW-1:0] len_log2(input logic [2:0] code);
    case (code)
      3'b001:  return 3'd2;
      3'b010:  return 3'd3;
      3'b011:  return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [WCNT_W-1:0] burst_words(input logic [LEN_LGW-1:0] lg);
    return WCNT_W'(1) << lg;
  endfunction

endpackage

// File: rtl/brs_cfg_reg.sv
module brs_cfg_reg
  import brs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] q,
  output brs_cfg_t         fields
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= CFG_RESET;
    else if (wr) q <= wdata & ~CFG_FIXED0;
  end

  always_comb begin
    fields.async_mode = q[15];
    fields.lat        = eff_latency(q[14:11]);
    fields.wait_hi    = q[10];
    fields.wait_early = q[8];
    fields.no_wrap    = q[3];
    fields.len_lg     = len_log2(q[2:0]);
  end

  always_comb begin
    AST_CFG_LAT_LEGAL: assert (!rst_n || fields.lat >= 4'd2); // R4
  end

endmodule

// File: rtl/brs_addr_step.sv
module brs_addr_step
  import brs_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0]      cur,
  input  logic [LEN_LGW-1:0] len_lg,
  input  logic               wrap,
  output logic [AW-1:0]      nxt
);

  logic [AW-1:0] inc;
  assign inc = cur + AW'(1);

  for (genvar i = 0; i < AW; i++) begin : g_bit
    logic above_win;
    assign above_win = (i >= int'(len_lg));
    assign nxt[i] = (wrap && len_lg != '0 && above_win) ? cur[i] : inc[i];
  end

endmodule

// File: rtl/brs_ctrl.sv
module brs_ctrl
  import brs_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  brs_cfg_t           cfg,
  input  logic               adv,
  input  logic [AW-1:0]      start_addr,
  input  logic               nonarray,
  input  logic               term,
  input  logic [DW-1:0]      arr_data,
  input  logic [AW-1:0]      nxt_addr,
  output logic [AW-1:0]      cur_addr,
  output logic [LEN_LGW-1:0] len_lg_act,
  output logic               wrap_act,
  output logic [DW-1:0]      dout,
  output logic               dvalid,
  output logic               wait_o
);

  brs_state_e         state;
  logic [LAT_W-1:0]   cnt;
  logic [WCNT_W-1:0]  wcnt;
  logic [AW-1:0]      base;
  logic               early_act;
  logic               rep_act;

  logic start_ev;
  logic emit_ev;
  logic last_done;
  logic wait_lvl;
  logic [WCNT_W-1:0] len_words;

  assign len_words = burst_words(len_lg_act);
  assign start_ev  = adv && !cfg.async_mode;
  assign last_done = (len_lg_act != '0) && (wcnt == len_words);
  assign emit_ev   = !start_ev && !term &&
                     (((state == ST_LAT) && (cnt == 4'd1)) ||
                      ((state == ST_DATA) && !last_done));
  assign wait_lvl  = (state == ST_LAT) && !(early_act && cnt == 4'd1);
  assign wait_o    = cfg.wait_hi ? wait_lvl : !wait_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      wcnt       <= '0;
      cur_addr   <= '0;
      base       <= '0;
      len_lg_act <= '0;
      wrap_act   <= 1'b0;
      early_act  <= 1'b0;
      rep_act    <= 1'b0;
      dout       <= '0;
      dvalid     <= 1'b0;
    end else if (start_ev) begin
      state      <= ST_LAT;
      cnt        <= cfg.lat;
      wcnt       <= '0;
      cur_addr   <= start_addr;
      base       <= start_addr;
      len_lg_act <= cfg.len_lg;
      wrap_act   <= !cfg.no_wrap && (cfg.len_lg != '0);
      early_act  <= cfg.wait_early;
      rep_act    <= nonarray;
      dvalid     <= 1'b0;
    end else if (term && state != ST_IDLE) begin
      state  <= ST_IDLE;
      dvalid <= 1'b0;
    end else if (emit_ev) begin
      state  <= ST_DATA;
      dout   <= arr_data;
      dvalid <= 1'b1;
      if (!rep_act) cur_addr <= nxt_addr;
      if (len_lg_act != '0) wcnt <= wcnt + WCNT_W'(1);
    end else if (state == ST_LAT) begin
      cnt <= cnt - LAT_W'(1);
    end else if (state == ST_DATA) begin
      state  <= ST_IDLE;
      dvalid <= 1'b0;
    end
  end

  AST_WAIT_DATA_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wait_lvl && dvalid)); // R10

  AST_LAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LAT && cnt > 4'd1 && !adv && !term) |=> (state == ST_LAT && !dvalid)); // R3

  AST_WORDS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (dvalid && len_lg_act != '0) |-> (wcnt <= len_words)); // R5

  AST_WRAP_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && wrap_act) |-> ((cur_addr >> len_lg_act) == (base >> len_lg_act))); // R6

  AST_ASYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.async_mode && state == ST_IDLE) |=> (state == ST_IDLE && !dvalid)); // R11

  AST_REPEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_act && state == ST_DATA && !adv) |=> $stable(cur_addr)); // R12

endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import brs_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [15:0]   cfg_wdata,
  output logic [15:0]   cfg_q,
  input  logic          adv,
  input  logic [AW-1:0] start_addr,
  input  logic          nonarray,
  input  logic          term,
  output logic [AW-1:0] arr_addr,
  input  logic [DW-1:0] arr_data,
  output logic [DW-1:0] dout,
  output logic          dvalid,
  output logic          wait_o
);

  brs_cfg_t           cfg_f;
  logic [AW-1:0]      cur_addr;
  logic [AW-1:0]      nxt_addr;
  logic [LEN_LGW-1:0] len_lg_act;
  logic               wrap_act;

  brs_cfg_reg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (cfg_wr),
    .wdata  (cfg_wdata),
    .q      (cfg_q),
    .fields (cfg_f)
  );

  brs_addr_step #(.AW(AW)) u_step (
    .cur    (cur_addr),
    .len_lg (len_lg_act),
    .wrap   (wrap_act),
    .nxt    (nxt_addr)
  );

  brs_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg        (cfg_f),
    .adv        (adv),
    .start_addr (start_addr),
    .nonarray   (nonarray),
    .term       (term),
    .arr_data   (arr_data),
    .nxt_addr   (nxt_addr),
    .cur_addr   (cur_addr),
    .len_lg_act (len_lg_act),
    .wrap_act   (wrap_act),
    .dout       (dout),
    .dvalid     (dvalid),
    .wait_o     (wait_o)
  );

  assign arr_addr = cur_addr;

endmodule

// File: tb/sim_burst_read_seq.sv
module sim_burst_read_seq;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [15:0]   cfg_wdata = '0;
  logic [15:0]   cfg_q;
  logic          adv = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          nonarray = 1'b0;
  logic          term = 1'b0;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_data;
  logic [DW-1:0] dout;
  logic          dvalid;
  logic          wait_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return a * 16'd7 + 16'h1234;
  endfunction

  assign arr_data = mem_word(arr_addr);

  burst_read_seq #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
    .adv(adv), .start_addr(start_addr), .nonarray(nonarray), .term(term),
    .arr_addr(arr_addr), .arr_data(arr_data), .dout(dout), .dvalid(dvalid), .wait_o(wait_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] a, input int k,
                                             input int len, input bit wrap, input bit rep);
    int lo;
    if (rep) return a;
    if (wrap && len > 0) begin
      lo = (int'(a) % len + k) % len;
      return (a / AW'(len)) * AW'(len) + AW'(lo);
    end
    return a + AW'(k);
  endfunction

  task automatic write_cfg(input logic [15:0] v);
    cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // len = 0 means continuous; ncyc = observed cycles before term or end
  task automatic run_burst(input string tag, input logic [15:0] cfgv, input logic [AW-1:0] a,
                           input bit rep, input int lc, input int len, input bit wrap,
                           input bit early, input bit pol, input int ncyc);
    bit dv_e, wl_e;
    write_cfg(cfgv);
    adv = 1'b1; start_addr = a; nonarray = rep;
    @(negedge clk);
    adv = 1'b0; nonarray = 1'b0;
    for (int i = 0; i < ncyc; i++) begin
      dv_e = (i >= lc) && (len == 0 || i < lc + len);
      wl_e = (i <= lc - 1) && !(early && i == lc - 1);
      chk($sformatf("%s dvalid c%0d", tag, i), dvalid, dv_e);
      chk($sformatf("%s wait c%0d", tag, i), wait_o, pol ? wl_e : !wl_e);
      if (dv_e)
        chk($sformatf("%s data c%0d", tag, i), dout,
            mem_word(exp_addr(a, i - lc, len, wrap, rep)));
      @(negedge clk);
    end
    if (len == 0) begin
      term = 1'b1;
      @(negedge clk);
      term = 1'b0;
      chk({tag, " R8 after term"}, dvalid, 1'b0);
    end
  endtask

  task automatic t_reset();
    chk("R1 cfg reset", cfg_q, 16'hF94F);
    chk("R1 dvalid reset", dvalid, 1'b0);
    chk("R1 wait reset", wait_o, 1'b1);
  endtask

  task automatic t_rsvd();
    write_cfg(16'hFFFF);
    chk("R2 reserved bits read 0", cfg_q, 16'hFDCF);
    write_cfg(16'h0000);
    chk("R2 clear readback", cfg_q, 16'h0000);
  endtask

  task automatic t_async();
    write_cfg(16'hF94F);
    adv = 1'b1; start_addr = 16'h0040;
    @(negedge clk);
    adv = 1'b0;
    for (int i = 0; i < 20; i++) begin
      chk($sformatf("R11 async dvalid c%0d", i), dvalid, 1'b0);
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rsvd();
    t_async();
    // R3 R5 R6 R10: LC 4, wrap, 4 words, wait low-active, released with data
    run_burst("R3 R6 wrap4", 16'h2041, 16'h0106, 1'b0, 4, 4, 1'b1, 1'b0, 1'b0, 11);
    // R7 R9 R10: LC 2, no wrap, 8 words, wait active high, early release
    run_burst("R7 R9 lin8", 16'h154A, 16'h00FE, 1'b0, 2, 8, 1'b0, 1'b1, 1'b1, 13);
    // R5 R6: LC 7, wrap, 16 words
    run_burst("R5 R6 wrap16", 16'h3843, 16'h003B, 1'b0, 7, 16, 1'b1, 1'b0, 1'b0, 26);
    // R4 R8: reserved latency 1 -> 15, reserved length 101 -> continuous
    run_burst("R4 R8 rsvd", 16'h0845, 16'h0200, 1'b0, 15, 0, 1'b0, 1'b0, 1'b0, 35);
    // R12: non-array repeat over 8 words with wrap
    run_burst("R12 repeat", 16'h1842, 16'h0031, 1'b1, 3, 8, 1'b1, 1'b0, 1'b0, 13);
    // R8 R7: continuous ignores wrap bit, crosses top of address space
    run_burst("R8 R7 cont", 16'h2047, 16'hFFFE, 1'b0, 4, 0, 1'b0, 1'b0, 1'b0, 12);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule